// File: doc/BRIEF.md
# Decade-divided glitch-free clock selector

The block turns a few fixed base clocks into a ladder of selectable clocks. Each base clock feeds a chain of divide-by-ten stages, so the undivided clock and every decade below it are all available. Two independent N:1 selectors, path A and path B, can each pick any clock from that ladder. A glitch-free switch then decides which of the two paths drives the output clock.

A caller asks for a frequency with a single request pulse that carries a frequency code. The controller runs in a separate control-clock domain. It writes the new code into whichever selector is not driving the output. On the next control cycle it moves the final switch over to that selector. The output never carries the clock of a selector that is being retargeted. A busy flag covers the whole exchange, and a one-cycle done pulse marks the moment the new path is confirmed live. The switch can only complete while both the old clock and the new clock are running.

Top module: `clk_decade_sel`

## Requirements
- R1: After reset, busy_o and done_o are 0 and active_o is 0, meaning path A drives clk_o. Both selectors hold code 0, so clk_o runs at base clock 0.
- R2: A frequency code c selects base clock c / NUM_DECADES divided by 10^(c % NUM_DECADES). Code 0 is base clock 0 undivided. With the defaults (2 bases, 3 decades) the valid codes are 0 to 5.
- R3: Each divide-by-ten stage toggles every 5 rising edges of its input. A divided output therefore has a high phase and a low phase of equal length.
- R4: When req_i is high at a control-clock edge, busy_o is low and req_code_i is valid, the request is accepted and busy_o is high from the next cycle.
- R5: At the accepting edge the new code is written into the idle selector. active_o inverts one control cycle later. Each accepted request swaps the paths, so path A and path B alternate.
- R6: done_o is a single-cycle pulse. It is raised once the enable of the new path has been seen high after the two-flop synchronizer. busy_o is 0 in the same cycle as done_o.
- R7: A request made while busy_o is high is ignored. The final output frequency is the one named by the earlier, accepted request.
- R8: A request whose code is NUM_BASE*NUM_DECADES or above is ignored: busy_o stays 0 and the clk_o period does not change.
- R9: clk_o is glitch-free. No high or low phase of clk_o is shorter than half the period of the faster of the old and new clocks. The two path enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_clk_i | input | NUM_BASE | Fixed base clocks; index 0 is the fastest |
| req_i | input | 1 | Frequency change request |
| req_code_i | input | CODE_W | Requested frequency code |
| busy_o | output | 1 | Change in progress |
| done_o | output | 1 | One-cycle pulse when the new path is live |
| active_o | output | 1 | Path driving clk_o: 0 is A, 1 is B |
| clk_o | output | 1 | Selected output clock |

## Verification
Each fault has its own signature at the ports:
- A divider stage with a wrong count shows up as a wrong output period or an unequal duty cycle. It appears within one output period after done_o.
- If the code is loaded into the live selector instead of the idle one, the output changes before active_o turns. This gives a short phase, or a period that does not match the code once the exchange is over.
- If the switch hands over without the interlock, the phase monitor sees a short pulse during that very exchange.
- A controller state error shows up within a few control cycles, as an active_o that does not flip or a done_o that is missing or lasts two cycles.

// File: rtl/clk_decade_sel_pkg.sv
package clk_decade_sel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_WAIT = 2'd2
  } sel_state_e;
endpackage

// File: rtl/div10_stage.sv
module div10_stage (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_o
);
  logic [2:0] cnt_q;
  logic       out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (cnt_q == 3'd4) begin
      cnt_q <= '0;
      out_q <= ~out_q;
    end else begin
      cnt_q <= cnt_q + 3'd1;
    end
  end

  assign clk_o = out_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 3'd4); // R3
  AST_TOGGLE_AT_FIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != 3'd4) |=> $stable(out_q)); // R3
endmodule

// File: rtl/decade_chain.sv
module decade_chain #(
  parameter int NUM_DECADES = 3
) (
  input  logic                   base_clk_i,
  input  logic                   rst_ni,
  output logic [NUM_DECADES-1:0] tap_o
);
  assign tap_o[0] = base_clk_i;

  for (genvar i = 1; i < NUM_DECADES; i++) begin : g_stage
    div10_stage u_div (
      .clk_i (tap_o[i-1]),
      .rst_ni(rst_ni),
      .clk_o (tap_o[i])
    );
  end
endmodule

// File: rtl/glitchless_switch.sv
module glitchless_switch (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic en_a_o,
  output logic en_b_o,
  output logic clk_o
);
  logic a_s1_q, a_q, b_s1_q, b_q;

  // each enable waits for the other path's enable to drop
  always_ff @(negedge clk_a_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_s1_q <= 1'b0;
      a_q    <= 1'b0;
    end else begin
      a_s1_q <= ~sel_i & ~b_q;
      a_q    <= a_s1_q;
    end
  end

  always_ff @(negedge clk_b_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_s1_q <= 1'b0;
      b_q    <= 1'b0;
    end else begin
      b_s1_q <= sel_i & ~a_q;
      b_q    <= b_s1_q;
    end
  end

  assign en_a_o = a_q;
  assign en_b_o = b_q;
  assign clk_o  = (clk_a_i & a_q) | (clk_b_i & b_q);

  always_comb begin
    AST_EXCLUSIVE_EN: assert ($onehot0({a_q, b_q})); // R9
  end
endmodule

// File: rtl/switch_ctrl.sv
module switch_ctrl
  import clk_decade_sel_pkg::*;
#(
  parameter int NUM_CLKS = 6,
  parameter int CODE_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CODE_W-1:0] req_code_i,
  input  logic              en_a_i,
  input  logic              en_b_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              sel_o,
  output logic              busy_o,
  output logic              done_o
);
  sel_state_e        state_q;
  logic [CODE_W-1:0] code_a_q, code_b_q;
  logic              sel_q, done_q;
  logic [1:0]        sync_a_q, sync_b_q;
  logic              code_ok, accept, new_live;

  assign code_ok  = ({1'b0, req_code_i} < (CODE_W+1)'(NUM_CLKS));
  assign accept   = req_i && (state_q == ST_IDLE) && code_ok;
  assign new_live = sel_q ? sync_b_q[1] : sync_a_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_a_q <= '0;
      sync_b_q <= '0;
    end else begin
      sync_a_q <= {sync_a_q[0], en_a_i};
      sync_b_q <= {sync_b_q[0], en_b_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      code_a_q <= '0;
      code_b_q <= '0;
      sel_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          // retarget the path that is not driving the output
          if (sel_q) code_a_q <= req_code_i;
          else       code_b_q <= req_code_i;
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          sel_q   <= ~sel_q;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (new_live) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign code_a_o = code_a_q;
  assign code_b_o = code_b_q;
  assign sel_o    = sel_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && code_ok) |=> busy_o); // R4
  AST_BAD_CODE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && !code_ok) |=> !busy_o); // R8
  AST_SEL_HELD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(sel_o)); // R5
  AST_LIVE_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_o && !$past(sel_o)) |-> $stable(code_a_o)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6
endmodule

// File: rtl/clk_decade_sel.sv
module clk_decade_sel #(
  parameter int NUM_BASE    = 2,
  parameter int NUM_DECADES = 3,
  parameter int NUM_CLKS    = NUM_BASE * NUM_DECADES,
  parameter int CODE_W      = (NUM_CLKS > 1) ? $clog2(NUM_CLKS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_BASE-1:0] base_clk_i,
  input  logic                req_i,
  input  logic [CODE_W-1:0]   req_code_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                active_o,
  output logic                clk_o
);
  logic [NUM_CLKS-1:0] ladder;
  logic [CODE_W-1:0]   code_a, code_b;
  logic                sel, en_a, en_b, path_a, path_b;

  for (genvar b = 0; b < NUM_BASE; b++) begin : g_base
    decade_chain #(.NUM_DECADES(NUM_DECADES)) u_chain (
      .base_clk_i(base_clk_i[b]),
      .rst_ni    (rst_ni),
      .tap_o     (ladder[b*NUM_DECADES +: NUM_DECADES])
    );
  end

  // selector codes are range-checked before loading
  assign path_a = ladder[code_a];
  assign path_b = ladder[code_b];

  switch_ctrl #(.NUM_CLKS(NUM_CLKS), .CODE_W(CODE_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .req_code_i(req_code_i),
    .en_a_i    (en_a),
    .en_b_i    (en_b),
    .code_a_o  (code_a),
    .code_b_o  (code_b),
    .sel_o     (sel),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  glitchless_switch u_switch (
    .clk_a_i(path_a),
    .clk_b_i(path_b),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .en_a_o (en_a),
    .en_b_o (en_b),
    .clk_o  (clk_o)
  );

  assign active_o = sel;

  AST_CODES_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, code_a} < (CODE_W+1)'(NUM_CLKS)) && ({1'b0, code_b} < (CODE_W+1)'(NUM_CLKS))); // R2
endmodule

// File: tb/clk_decade_sel_bench.sv
`timescale 1ns/1ps
module clk_decade_sel_bench;
  localparam int NB = 2;
  localparam int ND = 3;
  localparam int NC = NB * ND;
  localparam int CW = $clog2(NC);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] base = '0;
  logic          req = 1'b0;
  logic [CW-1:0] code = '0;
  logic          busy, done, active, clk_out;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;
  realtime min_phase = 5.0;
  realtime cur_per = 10.0;

  always #2 clk = ~clk;
  always #5 base[0] = ~base[0];
  always #7 base[1] = ~base[1];

  clk_decade_sel #(.NUM_BASE(NB), .NUM_DECADES(ND)) u_clk_decade_sel (
    .clk_i(clk), .rst_ni(rst_n), .base_clk_i(base), .req_i(req), .req_code_i(code),
    .busy_o(busy), .done_o(done), .active_o(active), .clk_o(clk_out)
  );

  function automatic realtime exp_period(int c);
    realtime p;
    p = (c / ND == 0) ? 10.0 : 14.0;
    for (int i = 0; i < c % ND; i++) p = p * 10.0;
    return p;
  endfunction

  task automatic chk(bit ok, string req_tag, realtime act, realtime exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req_tag, act, exp);
    end
  endtask

  // R9 phase monitor
  realtime last_t = 0.0;
  bit have_t = 1'b0;
  always @(clk_out) begin
    if (mon_en) begin
      if (have_t) chk(($realtime - last_t) >= min_phase - 0.001, "R9", $realtime - last_t, min_phase);
      last_t = $realtime;
      have_t = 1'b1;
    end
  end

  task automatic measure(int c, string tag);
    realtime t0, t1, t2;
    @(posedge clk_out); @(posedge clk_out);
    t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    chk(((t2 - t0) - exp_period(c)) < 0.01 && ((t2 - t0) - exp_period(c)) > -0.01,
        tag, t2 - t0, exp_period(c));
    chk(((t1 - t0) * 2.0 - (t2 - t0)) < 0.01 && ((t1 - t0) * 2.0 - (t2 - t0)) > -0.01,
        "R3", t1 - t0, (t2 - t0) / 2.0);
    @(negedge clk);
  endtask

  task automatic do_req(int c, bit inject, int inj_code);
    bit old_act;
    realtime np;
    bit seen;
    np = exp_period(c);
    min_phase = ((np < cur_per) ? np : cur_per) / 2.0;
    cur_per = np;
    @(negedge clk);
    req = 1'b1; code = CW'(c);
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R4", busy, 1);
    old_act = active;
    if (inject) begin req = 1'b1; code = CW'(inj_code); end
    @(negedge clk);
    req = 1'b0;
    chk(active != old_act, "R5", active, !old_act);
    seen = 1'b0;
    for (int i = 0; i < 6000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, "R6", seen, 1);
    chk(busy == 1'b0, "R6", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6", done, 0);
    chk(busy == 1'b0, "R7", busy, 0);
    measure(c, inject ? "R7" : "R2");
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(done == 1'b0, "R1", done, 0);
    chk(active == 1'b0, "R1", active, 0);
    measure(0, "R1");

    do_req(2, 1'b0, 0);
    // R8: invalid code leaves state and frequency alone
    @(negedge clk); req = 1'b1; code = CW'(7);
    @(negedge clk); req = 1'b0;
    chk(busy == 1'b0, "R8", busy, 0);
    chk(active == 1'b1, "R8", active, 1);
    measure(2, "R8");
    // R7: request while busy is dropped
    do_req(3, 1'b1, 1);
    do_req(0, 1'b0, 0);
    do_req(0, 1'b0, 0);
    do_req(5, 1'b0, 0);
    for (int k = 0; k < 8; k++) do_req(int'($urandom % NC), 1'b0, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule